// File: doc/BRIEF.md
# Ping-pong ADC serial output sequencer

This block is the digital control sequencer of a two-input delta-sigma converter that is read through a three-wire port: an active-low chip select, a serial clock supplied by the reader, and a serial data line. It launches a conversion, waits for the converter's done strobe, captures the result word and then sleeps, holding that word, until the reader drops chip select. The word then leaves the block most significant bit first. Once a read is over, the block flips the input channel it selects for the converter and starts the next conversion without being told to. The channels therefore take turns.

The analog modulator and decimation filter are outside this block. A one-cycle start strobe goes out to them, and a done strobe with the result word comes back. Chip select and serial clock are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are detected after synchronization. Whether a read counts as a read depends on whether a rising serial clock edge came before chip select rose again.

Top module: `pingpong_adc_seq`

## Requirements
- R1: The sequence after reset is launch, convert, sleep, output. The `conv_start` pulse is exactly one cycle wide, and a new launch follows every completed or aborted-after-clocking read.
- R2: `chan_sel` is 0 (channel 0) for the first conversion after reset. It inverts once at every launch that follows a read, so successive conversions use 0, 1, 0, 1.
- R3: In sleep with chip select high, the captured word is held unchanged for any length of time, `busy` is 0 and `sdo_oe` is 0.
- R4: The synchronized chip select going low in sleep enters the output state, with the word's bit RESULT_W-1 already on `sdo`.
- R5: If chip select rises before any rising serial clock edge, the block returns to sleep. The word is unchanged, `chan_sel` is unchanged and no `conv_start` is issued.
- R6: If chip select rises after one or more rising serial clock edges, output ends at that point, `chan_sel` inverts and a conversion is launched.
- R7: `sdo` advances one bit, MSB first, only on a falling serial clock edge that follows a rising edge while chip select is low. A reader therefore samples on rising edges.
- R8: The RESULT_W-th rising serial clock edge ends the output state and launches the next conversion on the other channel, with chip select still low.
- R9: Falling serial clock edges beyond RESULT_W bits put logic 1 on `sdo`. This lets a reader pad a transfer to 24 or 32 bits.
- R10: The word shifted out is the `conv_data` presented with the `conv_done` that ended the latest conversion. There is no pipeline delay.
- R11: `busy` is 1 from the cycle of `conv_start` until the cycle after `conv_done` is accepted. It is 0 otherwise.
- R12: `sdo_oe` is 1 exactly when the synchronized chip select is low. Chip select and serial clock take effect two system clocks after they are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csn | input | 1 | Chip select from reader, active low, asynchronous |
| sclk | input | 1 | Serial clock from reader, asynchronous, idles low |
| conv_done | input | 1 | One-cycle strobe: converter finished |
| conv_data | input | RESULT_W | Result word, valid with `conv_done` |
| conv_start | output | 1 | One-cycle strobe launching a conversion |
| busy | output | 1 | Conversion in flight |
| chan_sel | output | 1 | Selected input channel (0 or 1) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` (0 = high impedance) |

## Verification
On every cycle the assertions check these local rules: the start strobe is one cycle wide; busy stays up until done arrives; an abort with no clock edges goes back to sleep without touching the channel; the held word does not move while asleep; the bit count stays in range; and the last rising edge produces a launch with the channel flipped. Other behaviour needs complete scenarios, which only the bench runs: the channel alternating across several reads, the bit order and no-latency contents of a whole word, the ones used as padding after the word, and a partial read that still switches channel. The bench's behavioural model predicts every output on every cycle across these scenarios.

// File: rtl/pingpong_pkg.sv
package pingpong_pkg;

    typedef enum logic [1:0] {
        ST_LAUNCH  = 2'd0,
        ST_CONVERT = 2'd1,
        ST_SLEEP   = 2'd2,
        ST_SHIFT   = 2'd3
    } seq_state_e;

    // Synchronized pin: current level and level one clock earlier
    typedef struct packed {
        logic level;
        logic prev;
    } pin_evt_t;

    function automatic logic is_rise(input pin_evt_t e);
        return e.level & ~e.prev;
    endfunction

    function automatic logic is_fall(input pin_evt_t e);
        return ~e.level & e.prev;
    endfunction

    function automatic logic other_chan(input logic c);
        return ~c;
    endfunction

endpackage

// File: rtl/sync_edge.sv
module sync_edge
    import pingpong_pkg::*;
#(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    output pin_evt_t evt
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {CHAIN_W{RESET_VAL}};
        else     chain <= {chain[CHAIN_W-2:0], pin};
    end

    assign evt.level = chain[STAGES-1];
    assign evt.prev  = chain[STAGES];
endmodule

// File: rtl/result_shifter.sv
module result_shifter #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] data,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst)        shreg <= '1;
        else if (load)  shreg <= data;
        else if (shift) shreg <= {shreg[W-2:0], 1'b1};
    end

    assign msb = shreg[W-1];

    AST_SHIFT_FILLS_ONE: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> shreg[0]) else $error("fill bit not one"); // R9
endmodule

// File: rtl/pingpong_adc_seq.sv
module pingpong_adc_seq
    import pingpong_pkg::*;
#(
    parameter int RESULT_W    = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                csn,
    input  logic                sclk,
    input  logic                conv_done,
    input  logic [RESULT_W-1:0] conv_data,
    output logic                conv_start,
    output logic                busy,
    output logic                chan_sel,
    output logic                sdo,
    output logic                sdo_oe
);
    localparam int CNT_W = $clog2(RESULT_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(RESULT_W - 1);

    seq_state_e     state;
    pin_evt_t       cs_e, sk_e;
    logic [CNT_W-1:0] bit_cnt;
    logic           seen_rise;
    logic           load, shift_en;

    sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst(rst), .pin(csn), .evt(cs_e));

    sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sk_sync (
        .clk(clk), .rst(rst), .pin(sclk), .evt(sk_e));

    assign load     = (state == ST_CONVERT) && conv_done;
    assign shift_en = is_fall(sk_e) && !cs_e.level && seen_rise;

    result_shifter #(.W(RESULT_W)) u_shift (
        .clk(clk), .rst(rst), .load(load), .data(conv_data),
        .shift(shift_en), .msb(sdo));

    // A rising serial clock while selected marks the read as started
    always_ff @(posedge clk) begin
        if (rst || cs_e.level || load) seen_rise <= 1'b0;
        else if (is_rise(sk_e))        seen_rise <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_LAUNCH;
            chan_sel <= 1'b0;
            bit_cnt  <= '0;
        end else begin
            unique case (state)
                ST_LAUNCH:  state <= ST_CONVERT;
                ST_CONVERT: if (conv_done) state <= ST_SLEEP;
                ST_SLEEP: begin
                    if (!cs_e.level) begin
                        state   <= ST_SHIFT;
                        bit_cnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (is_rise(cs_e)) begin
                        if (seen_rise) begin
                            state    <= ST_LAUNCH;
                            chan_sel <= other_chan(chan_sel);
                        end else begin
                            state <= ST_SLEEP;
                        end
                    end else if (is_rise(sk_e)) begin
                        if (bit_cnt == LAST_BIT) begin
                            state    <= ST_LAUNCH;
                            chan_sel <= other_chan(chan_sel);
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_LAUNCH;
            endcase
        end
    end

    assign conv_start = (state == ST_LAUNCH);
    assign busy       = (state == ST_LAUNCH) || (state == ST_CONVERT);
    assign sdo_oe     = ~cs_e.level;

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start) else $error("start too long"); // R1
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONVERT && !conv_done) |=> busy) else $error("busy dropped"); // R11
    AST_ABORT_KEEPS_CHAN: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && is_rise(cs_e) && !seen_rise)
        |=> (state == ST_SLEEP && $stable(chan_sel) && !conv_start)) else $error("abort moved"); // R5
    AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && cs_e.level) |=> $stable(sdo)) else $error("held word moved"); // R3
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT) |-> (bit_cnt <= LAST_BIT)) else $error("count overrun"); // R8
    AST_LAST_EDGE_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && !cs_e.level && is_rise(sk_e) && bit_cnt == LAST_BIT)
        |=> (conv_start && chan_sel != $past(chan_sel))) else $error("no relaunch"); // R8
endmodule

// File: tb/pingpong_adc_seq_bench.sv
module pingpong_adc_seq_bench;
    localparam int CLK_P = 10;
    localparam int W     = 19;
    localparam int H     = 6;     // sclk half period in system clocks
    localparam int LAT   = 300;   // converter latency

    logic clk = 1'b0, rst = 1'b1, csn = 1'b1, sclk = 1'b0, conv_done = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic conv_start, busy, chan_sel, sdo, sdo_oe;

    int n_cmp = 0, n_bad = 0, cyc = 0, conv_cnt = 0, lat_cnt = -1;
    bit done_flag = 1'b0;

    pingpong_adc_seq #(.RESULT_W(W), .SYNC_STAGES(2)) u_pingpong_adc_seq (
        .clk(clk), .rst(rst), .csn(csn), .sclk(sclk), .conv_done(conv_done),
        .conv_data(conv_data), .conv_start(conv_start), .busy(busy),
        .chan_sel(chan_sel), .sdo(sdo), .sdo_oe(sdo_oe));

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [W-1:0] word_of(input int k);
        return W'(32'h2B3C5 ^ (k * 32'h0F1D3) ^ (k << 11));
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Converter stand-in
    always @(negedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) lat_cnt <= LAT;
        else if (lat_cnt > 0) lat_cnt <= lat_cnt - 1;
        else if (lat_cnt == 0) begin
            conv_done <= 1'b1;
            conv_data <= word_of(conv_cnt);
            conv_cnt  <= conv_cnt + 1;
            lat_cnt   <= -1;
        end
    end

    // Behavioural reference model
    bit qcs[$], qsk[$];
    int mph, mshifts, mcnt;
    bit mchan, mseen;
    logic [W-1:0] mres;

    always @(posedge clk) begin
        if (rst) begin
            mph = 0; mchan = 0; mres = '1; mshifts = 0; mcnt = 0; mseen = 0;
            qcs = '{1, 1, 1}; qsk = '{0, 0, 0};
        end else begin
            bit lvl, srise, sfall, ld, nseen;
            lvl   = qcs[1];
            srise = qsk[1] && !qsk[2];
            sfall = !qsk[1] && qsk[2];
            ld    = (mph == 1) && conv_done;
            nseen = (lvl || ld) ? 1'b0 : (srise ? 1'b1 : mseen);
            if (ld) begin mres = conv_data; mshifts = 0; end
            else if (sfall && !lvl && mseen && mshifts < 1000) mshifts++;
            case (mph)
                0: mph = 1;
                1: if (ld) mph = 2;
                2: if (!lvl) begin mph = 3; mcnt = 0; end
                default: begin
                    if (lvl) begin
                        if (mseen) begin mph = 0; mchan = !mchan; end
                        else mph = 2;
                    end else if (srise) begin
                        if (mcnt == W - 1) begin mph = 0; mchan = !mchan; end
                        else mcnt++;
                    end
                end
            endcase
            mseen = nseen;
            qcs.push_front(csn);  void'(qcs.pop_back());
            qsk.push_front(sclk); void'(qsk.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R1 conv_start", conv_start, (mph == 0));
            chk("R11 busy", busy, (mph <= 1));
            chk("R2 chan_sel", chan_sel, mchan);
            chk("R12 sdo_oe", sdo_oe, !qcs[1]);
            chk("R7 sdo", sdo, (mshifts < W) ? mres[W-1-mshifts] : 1'b1);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic clock_bits(input int n, output logic [63:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            wait_n(H);
            got = {got[62:0], sdo};
            sclk = 1'b1;
            wait_n(H);
            sclk = 1'b0;
        end
    endtask

    initial begin
        logic [63:0] got;
        wait_n(5);
        chk("R2 reset channel", chan_sel, 1'b0);
        chk("R12 reset oe", sdo_oe, 1'b0);
        rst = 1'b0;

        // first conversion on channel 0
        wait_idle(); wait_n(10);
        chk("R3 sleep busy", busy, 1'b0);
        chk("R3 sleep oe", sdo_oe, 1'b0);

        // select, no clock, deselect
        csn = 1'b0; wait_n(8);
        chk("R4 oe on select", sdo_oe, 1'b1);
        chk("R4 msb on select", sdo, word_of(0)[W-1]);
        csn = 1'b1; wait_n(8);
        chk("R5 chan kept", chan_sel, 1'b0);
        chk("R5 no launch", busy, 1'b0);

        // full read, then padding bits
        csn = 1'b0; wait_n(8);
        clock_bits(W, got);
        chk("R10 word0", got[W-1:0], word_of(0));
        wait_n(4);
        chk("R8 relaunch busy", busy, 1'b1);
        chk("R8 chan flipped", chan_sel, 1'b1);
        clock_bits(5, got);
        chk("R9 pad ones", got[4:0], 5'h1F);
        csn = 1'b1;

        // partial read, then deselect
        wait_idle(); wait_n(10);
        csn = 1'b0; wait_n(8);
        clock_bits(7, got);
        chk("R7 partial bits", got[6:0], word_of(1)[W-1:W-7]);
        csn = 1'b1; wait_n(5);
        chk("R6 relaunch busy", busy, 1'b1);
        chk("R6 chan flipped", chan_sel, 1'b0);

        // 32-bit read after long sleep
        wait_idle(); wait_n(40);
        chk("R3 long sleep oe", sdo_oe, 1'b0);
        csn = 1'b0; wait_n(8);
        clock_bits(32, got);
        chk("R10 word2", got[31:32-W], word_of(2));
        chk("R9 pad 32", got[31-W:0], {(32-W){1'b1}});
        chk("R2 chan after third", chan_sel, 1'b1);
        csn = 1'b1; wait_n(10);

        summary();
        $finish;
    end
endmodule